// File: doc/BRIEF.md
# Trace Buffer Occupancy Counter

This block tracks how much of a circular on-chip trace buffer holds valid captured data during a debug session. Each store strobe delivers half of one buffer line. The block keeps a read-only occupancy count in half-line units, steers each half into the right line and half of the buffer, and raises a sticky full flag when the count wraps.

What happens after the wrap depends on the trigger alignment. In begin alignment the session ends and the block disarms. In mid and end alignment capture continues, and the newest data overwrites the oldest. Writing a one to the arm control starts a fresh session.

The count, the full flag and the buffer contents survive a system reset, so software can still inspect a capture after the chip recovers. Only power-on reset clears them. Reading the buffer through the read port never alters the count.

Top module: `tbuf_occupancy`

## Requirements
- R1: After power-on reset, `count`, `wr_ptr`, `full` and `armed` are all zero.
- R2: While `armed` is 1 and `arm_wr` is 0, each cycle with `store_stb` high increments `count` by exactly one at the next clock edge.
- R3: `wr_ptr` equals `count` shifted right by one. A strobe taken with `count` even writes `store_data` into bits 31:0 of line `wr_ptr`; a strobe taken with `count` odd writes bits 63:32 of that line.
- R4: A strobe taken at `count` = 127 sets `count` to 0 and sets `full` to 1.
- R5: With `align_mode` 2'b01 (mid) or 2'b10 (end), `armed` stays 1 across the wrap and counting continues, so later strobes overwrite the oldest lines starting at line 0. The value 2'b11 behaves as end alignment.
- R6: With `align_mode` 2'b00 (begin), the wrapping strobe clears `armed` and ends the session. Later strobes change neither the count nor the buffer.
- R7: A cycle with `arm_wr` high sets `armed` to 1 and clears `count` and `full` at the next edge. A strobe in the same cycle is dropped.
- R8: Asserting `sys_rst_n` low clears `armed` but leaves `count`, `full` and the buffer contents unchanged.
- R9: Strobes that arrive while `armed` is 0 change neither `count` nor `wr_ptr`.
- R10: A read of line `rd_line` returns that line on `rd_data` one cycle later, and reads never change `count`.
- R11: Once set, `full` stays 1 until power-on reset or an `arm_wr` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sys_rst_n | input | 1 | System reset, active low; clears only the session state |
| arm_wr | input | 1 | One-cycle pulse for writing a one to the arm control |
| align_mode | input | 2 | Trigger alignment: 00 begin, 01 mid, 10 or 11 end |
| store_stb | input | 1 | Half-line store strobe |
| store_data | input | 32 | Half-line data to store |
| rd_line | input | 6 | Buffer line to read |
| rd_data | output | 64 | Line contents, registered one cycle after `rd_line` |
| count | output | 7 | Occupancy count in half-line units |
| wr_ptr | output | 6 | Line currently being filled |
| full | output | 1 | Sticky buffer-full flag |
| armed | output | 1 | Session active |

## Verification
The bench drives the count through the 127-to-0 wrap in both mid and begin alignment. It checks that mid alignment keeps counting and overwrites line 0, and that begin alignment disarms. A design that tested the wrong alignment would either freeze mid-mode capture or overrun a begin-mode capture.

A system reset is pulsed in the middle of a session. The bench then checks that the count, the flag and the stored lines remain, which catches counters tied to the wrong reset.

An arm write is made in the same cycle as a strobe, and strobes are sent while disarmed. Either of these would leave a stray count of one if priority or gating were wrong.

Half ordering is checked by reading lines back. A swapped half select shows up as exchanged 32-bit words.

// File: rtl/tbo_pkg.sv
package tbo_pkg;

   typedef enum logic [1:0] {
      ALIGN_BEGIN   = 2'b00,
      ALIGN_MID     = 2'b01,
      ALIGN_END     = 2'b10,
      ALIGN_END_ALT = 2'b11
   } align_e;

   function automatic logic stops_on_full(input align_e m);
      return (m == ALIGN_BEGIN);
   endfunction

endpackage

// File: rtl/tbo_session_ctl.sv
module tbo_session_ctl
   import tbo_pkg::*;
(
   input  logic       clk,
   input  logic       por_n,
   input  logic       sys_rst_n,
   input  logic       arm_wr,
   input  logic [1:0] align_mode,
   input  logic       wrap_evt,
   output logic       armed
);

   logic   ctl_rst_n;
   align_e mode_q;
   logic   stop_now;

   assign ctl_rst_n = por_n & sys_rst_n;
   assign mode_q    = align_e'(align_mode);
   assign stop_now  = wrap_evt & stops_on_full(mode_q);

   always_ff @(posedge clk or negedge ctl_rst_n) begin
      if (!ctl_rst_n) begin
         armed <= 1'b0;
      end else if (arm_wr) begin
         armed <= 1'b1;
      end else if (stop_now) begin
         armed <= 1'b0;
      end
   end

   p_begin_stop_r6: assert property (@(posedge clk) disable iff (!ctl_rst_n)
      (wrap_evt && !arm_wr && align_mode == 2'b00) |=> !armed);

   p_keep_running_r5: assert property (@(posedge clk) disable iff (!ctl_rst_n)
      (armed && wrap_evt && align_mode != 2'b00) |=> armed);

   p_arm_sets_r7: assert property (@(posedge clk) disable iff (!ctl_rst_n)
      arm_wr |=> armed);

endmodule

// File: rtl/tbo_occ_counter.sv
module tbo_occ_counter #(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             por_n,
   input  logic             arm_wr,
   input  logic             accept,
   output logic [CNT_W-1:0] count,
   output logic             full,
   output logic             wrap_evt
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   assign wrap_evt = accept & (count == CNT_MAX);

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         count <= '0;
      end else if (arm_wr) begin
         count <= '0;
      end else if (accept) begin
         count <= count + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
         full <= 1'b0;
      end else if (arm_wr) begin
         full <= 1'b0;
      end else if (wrap_evt) begin
         full <= 1'b1;
      end
   end

   p_count_step_r2: assert property (@(posedge clk) disable iff (!por_n)
      (accept && !arm_wr) |=> count == $past(count) + 1'b1);

   p_wrap_full_r4: assert property (@(posedge clk) disable iff (!por_n)
      (accept && !arm_wr && count == CNT_MAX) |=> (full && count == '0));

   p_full_sticky_r11: assert property (@(posedge clk) disable iff (!por_n)
      (full && !arm_wr) |=> full);

   p_arm_clears_r7: assert property (@(posedge clk) disable iff (!por_n)
      arm_wr |=> (count == '0 && !full));

endmodule

// File: rtl/tbo_trace_ram.sv
module tbo_trace_ram #(
   parameter int LINE_W   = 64,
   parameter int DEPTH    = 64,
   parameter int READ_REG = 1,
   localparam int HALF_W  = LINE_W / 2,
   localparam int PTR_W   = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              we,
   input  logic [PTR_W-1:0]  wr_line,
   input  logic              wr_upper,
   input  logic [HALF_W-1:0] wr_data,
   input  logic [PTR_W-1:0]  rd_line,
   output logic [LINE_W-1:0] rd_data
);

   logic [LINE_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         if (wr_upper) begin
            mem[wr_line][LINE_W-1:HALF_W] <= wr_data;
         end else begin
            mem[wr_line][HALF_W-1:0] <= wr_data;
         end
      end
   end

   generate
      if (READ_REG != 0) begin : g_rd_reg
         always_ff @(posedge clk) begin
            rd_data <= mem[rd_line];
         end
      end else begin : g_rd_comb
         assign rd_data = mem[rd_line];
      end
   endgenerate

endmodule

// File: rtl/tbuf_occupancy.sv
module tbuf_occupancy #(
   parameter int  LINE_W   = 64,
   parameter int  DEPTH    = 64,
   parameter int  READ_REG = 1,
   localparam int HALF_W   = LINE_W / 2,
   localparam int PTR_W    = $clog2(DEPTH),
   localparam int CNT_W    = PTR_W + 1
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              sys_rst_n,
   input  logic              arm_wr,
   input  logic [1:0]        align_mode,
   input  logic              store_stb,
   input  logic [HALF_W-1:0] store_data,
   input  logic [PTR_W-1:0]  rd_line,
   output logic [LINE_W-1:0] rd_data,
   output logic [CNT_W-1:0]  count,
   output logic [PTR_W-1:0]  wr_ptr,
   output logic              full,
   output logic              armed
);

   generate
      if (LINE_W % 2 != 0) begin : g_bad_line
         $error("LINE_W must be even");
      end
      if (DEPTH < 2 || (1 << PTR_W) != DEPTH) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic accept;
   logic wrap_evt;

   assign accept = store_stb & armed & ~arm_wr;
   assign wr_ptr = count[CNT_W-1:1];

   tbo_session_ctl u_ctl (
      .clk        (clk),
      .por_n      (por_n),
      .sys_rst_n  (sys_rst_n),
      .arm_wr     (arm_wr),
      .align_mode (align_mode),
      .wrap_evt   (wrap_evt),
      .armed      (armed)
   );

   tbo_occ_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .por_n    (por_n),
      .arm_wr   (arm_wr),
      .accept   (accept),
      .count    (count),
      .full     (full),
      .wrap_evt (wrap_evt)
   );

   tbo_trace_ram #(.LINE_W(LINE_W), .DEPTH(DEPTH), .READ_REG(READ_REG)) u_ram (
      .clk      (clk),
      .we       (accept),
      .wr_line  (wr_ptr),
      .wr_upper (count[0]),
      .wr_data  (store_data),
      .rd_line  (rd_line),
      .rd_data  (rd_data)
   );

   p_idle_ignored_r9: assert property (@(posedge clk) disable iff (!por_n)
      (!armed && !arm_wr) |=> ($stable(count) && $stable(wr_ptr)));

   p_sysrst_keeps_r8: assert property (@(posedge clk) disable iff (!por_n)
      (!sys_rst_n && !arm_wr) |=> ($stable(count) && $stable(full)));

   p_sysrst_disarms_r8: assert property (@(posedge clk) disable iff (!por_n)
      !sys_rst_n |-> !armed);

endmodule

// File: tb/test_tbuf_occupancy.sv
module test_tbuf_occupancy;

   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        sys_rst_n = 1'b1;
   logic        arm_wr = 1'b0;
   logic [1:0]  align_mode = 2'b00;
   logic        store_stb = 1'b0;
   logic [31:0] store_data = '0;
   logic [5:0]  rd_line = '0;
   logic [63:0] rd_data;
   logic [6:0]  count;
   logic [5:0]  wr_ptr;
   logic        full;
   logic        armed;

   int n_checks = 0;
   int n_errs   = 0;

   always #4 clk = ~clk;

   tbuf_occupancy i_tbuf_occupancy (
      .clk        (clk),
      .por_n      (por_n),
      .sys_rst_n  (sys_rst_n),
      .arm_wr     (arm_wr),
      .align_mode (align_mode),
      .store_stb  (store_stb),
      .store_data (store_data),
      .rd_line    (rd_line),
      .rd_data    (rd_data),
      .count      (count),
      .wr_ptr     (wr_ptr),
      .full       (full),
      .armed      (armed)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errs++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_arm(input logic [1:0] m);
      @(negedge clk);
      arm_wr = 1'b1;
      align_mode = m;
      @(negedge clk);
      arm_wr = 1'b0;
   endtask

   task automatic push(input int n, input logic [31:0] base);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         store_stb  = 1'b1;
         store_data = base + 32'(i);
      end
      @(negedge clk);
      store_stb = 1'b0;
   endtask

   task automatic read_line(input logic [5:0] l, output logic [63:0] d);
      @(negedge clk);
      rd_line = l;
      @(negedge clk);
      d = rd_data;
   endtask

   task automatic t_reset();
      check("R1 count", 64'(count), 64'd0);
      check("R1 wr_ptr", 64'(wr_ptr), 64'd0);
      check("R1 full", 64'(full), 64'd0);
      check("R1 armed", 64'(armed), 64'd0);
   endtask

   task automatic t_partial();
      logic [63:0] d;
      do_arm(2'b10);
      check("R7 armed", 64'(armed), 64'd1);
      push(3, 32'h1000);
      check("R2 count", 64'(count), 64'd3);
      check("R3 wr_ptr", 64'(wr_ptr), 64'd1);
      read_line(6'd0, d);
      check("R3 line0 halves", d, {32'h1001, 32'h1000});
      read_line(6'd1, d);
      check("R3 line1 lower", 64'(d[31:0]), 64'h1002);
      check("R10 count after reads", 64'(count), 64'd3);
   endtask

   task automatic t_sysrst();
      logic [63:0] d;
      do_arm(2'b01);
      push(5, 32'h100);
      @(negedge clk);
      sys_rst_n = 1'b0;
      @(negedge clk);
      sys_rst_n = 1'b1;
      check("R8 count kept", 64'(count), 64'd5);
      check("R8 armed cleared", 64'(armed), 64'd0);
      check("R8 wr_ptr kept", 64'(wr_ptr), 64'd2);
      read_line(6'd1, d);
      check("R8 data kept", d, {32'h103, 32'h102});
      read_line(6'd0, d);
      check("R10 count unchanged", 64'(count), 64'd5);
      push(2, 32'hBAD0);
      check("R9 count ignored", 64'(count), 64'd5);
      check("R9 wr_ptr ignored", 64'(wr_ptr), 64'd2);
   endtask

   task automatic t_wrap_mid();
      logic [63:0] d;
      do_arm(2'b01);
      push(127, 32'h0);
      check("R2 count 127", 64'(count), 64'd127);
      check("R4 full before wrap", 64'(full), 64'd0);
      push(1, 32'd127);
      check("R4 count wrapped", 64'(count), 64'd0);
      check("R4 full set", 64'(full), 64'd1);
      check("R5 still armed", 64'(armed), 64'd1);
      read_line(6'd5, d);
      check("R3 line5", d, {32'd11, 32'd10});
      push(2, 32'hA0);
      check("R5 counting on", 64'(count), 64'd2);
      read_line(6'd0, d);
      check("R5 overwrite", d, {32'hA1, 32'hA0});
      check("R11 full sticky", 64'(full), 64'd1);
      @(negedge clk);
      sys_rst_n = 1'b0;
      @(negedge clk);
      sys_rst_n = 1'b1;
      check("R8 full kept", 64'(full), 64'd1);
   endtask

   task automatic t_wrap_begin();
      logic [63:0] d;
      do_arm(2'b00);
      check("R7 full cleared", 64'(full), 64'd0);
      push(127, 32'h0);
      check("R6 armed before", 64'(armed), 64'd1);
      push(1, 32'd127);
      check("R6 count wrapped", 64'(count), 64'd0);
      check("R6 full", 64'(full), 64'd1);
      check("R6 disarmed", 64'(armed), 64'd0);
      push(3, 32'hDEAD0);
      check("R6 count frozen", 64'(count), 64'd0);
      read_line(6'd0, d);
      check("R6 line0 kept", d, {32'd1, 32'd0});
   endtask

   task automatic t_arm_priority();
      @(negedge clk);
      arm_wr = 1'b1;
      align_mode = 2'b11;
      store_stb = 1'b1;
      store_data = 32'h55;
      @(negedge clk);
      arm_wr = 1'b0;
      store_stb = 1'b0;
      check("R7 count cleared", 64'(count), 64'd0);
      check("R7 full cleared", 64'(full), 64'd0);
      check("R7 armed", 64'(armed), 64'd1);
      push(1, 32'h66);
      check("R2 first after arm", 64'(count), 64'd1);
   endtask

   task automatic t_por();
      push(4, 32'h70);
      @(negedge clk);
      por_n = 1'b0;
      @(negedge clk);
      t_reset();
      por_n = 1'b1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      por_n = 1'b1;
      @(negedge clk);
      t_partial();
      t_sysrst();
      t_wrap_mid();
      t_wrap_begin();
      t_arm_priority();
      t_por();
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_errs++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
      $finish;
   end

endmodule